// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block sits between a narrow, byte-wide synchronous host bus and a 32 KB internal byte space made of registers and packet buffers. Each host read or write turns into at most one byte access on the internal memory port. A small mode register, always reachable at host offset zero, picks how the host address is read. In direct mode the whole host address maps one to one onto the internal space. In indirect mode only a four-byte window is decoded: the mode register, a two-byte internal address pointer, and a data port that reaches the byte the pointer names.

When the auto-increment flag is set, each data-port access moves the pointer up by one. A host can therefore stream a buffer, or read a 16-bit register high byte first, with a single pointer load. The pointer counts linearly over the 15-bit space and knows nothing about buffer regions. Writing the top bit of the mode register starts a soft reset. The reset clears the bridge state, signals the internal space, and ends by itself after a set number of cycles. Read data comes back through a registered path and is valid in the cycle after the strobe.

Top module: `ixb_top`

## Requirements
- R1: After reset the mode register reads 0x00 (direct mode), `soft_rst` and `ping_block` are low, and no memory strobe is raised while the host is idle.
- R2: In direct mode a host access at any non-zero address A raises exactly one memory strobe at internal address A: `mem_we` with `mem_wdata` equal to the host data for a write, and `mem_re` for a read.
- R3: The mode register decodes at host address 0 in both modes. Bit 4 drives `ping_block`, bit 1 enables auto-increment and bit 0 selects indirect mode. All other bits except bit 7 are discarded and read as 0.
- R4: In indirect mode only `host_addr[1:0]` is decoded. Offset 1 holds the pointer's high byte and offset 2 its low byte, and both read back. Bit 7 written to offset 1 is ignored and reads as 0.
- R5: In indirect mode an access at offset 3 reaches internal address equal to the pointer. A read returns the byte at the pointer as it was before any increment.
- R6: With auto-increment set, each data-port read or write raises the pointer by one. With it clear, the pointer does not move.
- R7: The increment is a plain 15-bit count: 0x5FFF steps to 0x6000 and 0x7FFF steps to 0x0000.
- R8: A data-port access while the pointer is 0 reaches the mode register instead of the memory port.
- R9: Writing a 1 to mode bit 7, directly or through the data port, clears the mode flags and the pointer. It holds `soft_rst` high for RST_CYCLES cycles, during which the mode register reads 0x80, and the block then returns to direct mode reading 0x00.
- R10: While `soft_rst` is high, host writes have no effect, no memory strobe is raised, and every host read returns 0x80.
- R11: Read data appears on `host_rdata` in the cycle that follows the read strobe, for local and internal targets alike.
- R12: A cycle with both read and write strobes is a write only: no `mem_re` is raised and no read data is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs | input | 1 | Host chip select, qualifies the strobes |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_addr | input | AW | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| mem_addr | output | AW | Internal byte address |
| mem_we | output | 1 | Internal write strobe |
| mem_re | output | 1 | Internal read strobe |
| mem_wdata | output | 8 | Internal write data |
| mem_rdata | input | 8 | Internal read data, one cycle after `mem_re` |
| soft_rst | output | 1 | High while a soft reset is in progress |
| ping_block | output | 1 | Current value of the ping-block mode flag |

## Verification
Two functions can fall in one cycle here. The first pair is a data-port read and the pointer increment: the bench reads through the data port with auto-increment on and checks that the byte returned belongs to the old pointer while the pointer readback shows the new one. The second pair is a data-port write that lands on the mode register with bit 7 set while auto-increment is on. In that cycle the reset and the increment both act on the pointer, and the reset must win, so the pointer must read back as zero rather than one. A behavioural model in the bench predicts the memory strobes, address, write data and status outputs on every clock and the read data on the cycle after each read, and compares them all.

// File: rtl/ixb_pkg.sv
package ixb_pkg;
   // Mode register bit positions (software-visible encoding)
   localparam int MB_RST = 7;
   localparam int MB_PB  = 4;
   localparam int MB_AI  = 1;
   localparam int MB_IND = 0;
   localparam logic [7:0] MODE_KEEP = 8'((1 << MB_PB) | (1 << MB_AI) | (1 << MB_IND));

   // Decoded target of one host access
   typedef enum logic [1:0] {
      TGT_MODE = 2'd0,
      TGT_PHI  = 2'd1,
      TGT_PLO  = 2'd2,
      TGT_MEM  = 2'd3
   } tgt_e;
endpackage

// File: rtl/ixb_mode.sv
module ixb_mode #(
   parameter int RST_CYCLES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wdata,
   output logic       busy,
   output logic       pb,
   output logic       ai,
   output logic       ind,
   output logic [7:0] rd_byte
);
   import ixb_pkg::*;

   localparam int CW = $clog2(RST_CYCLES + 1);

   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("ixb_mode: RST_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic [7:0]    flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         flags_q <= '0;
      end else if (wr_en && wdata[MB_RST]) begin
         cnt_q   <= CW'(RST_CYCLES);
         flags_q <= '0;
      end else if (wr_en) begin
         flags_q <= wdata & MODE_KEEP;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy    = (cnt_q != '0);
   assign pb      = flags_q[MB_PB];
   assign ai      = flags_q[MB_AI];
   assign ind     = flags_q[MB_IND];
   assign rd_byte = flags_q | {busy, 7'b0};
endmodule

// File: rtl/ixb_ptr.sv
module ixb_ptr #(
   parameter int AW = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          ld_hi,
   input  logic          ld_lo,
   input  logic          step,
   input  logic [7:0]    wdata,
   output logic [AW-1:0] ptr,
   output logic [7:0]    rd_hi,
   output logic [7:0]    rd_lo
);
   logic [AW-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (clr) begin
         ptr_q <= '0;
      end else if (ld_hi) begin
         ptr_q <= AW'({wdata, ptr_q[7:0]});
      end else if (ld_lo) begin
         ptr_q <= {ptr_q[AW-1:8], wdata};
      end else if (step) begin
         ptr_q <= ptr_q + 1'b1;
      end
   end

   assign ptr   = ptr_q;
   assign rd_hi = 8'(ptr_q >> 8);
   assign rd_lo = ptr_q[7:0];
endmodule

// File: rtl/ixb_rdpath.sv
module ixb_rdpath #(
   parameter bit MEM_SYNC = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_local,
   input  logic       rd_mem,
   input  logic [7:0] local_byte,
   input  logic [7:0] mem_rdata,
   output logic [7:0] rdata
);
   logic [7:0] hold_q;

   if (MEM_SYNC) begin : g_sync_mem
      // Memory returns data one cycle after the strobe; only the source is remembered.
      logic sel_local_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sel_local_q <= 1'b1;
            hold_q      <= '0;
         end else if (rd_local) begin
            sel_local_q <= 1'b1;
            hold_q      <= local_byte;
         end else if (rd_mem) begin
            sel_local_q <= 1'b0;
         end
      end
      assign rdata = sel_local_q ? hold_q : mem_rdata;
   end else begin : g_comb_mem
      // Memory answers in the strobe cycle; the bridge captures it.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_q <= '0;
         end else if (rd_local) begin
            hold_q <= local_byte;
         end else if (rd_mem) begin
            hold_q <= mem_rdata;
         end
      end
      assign rdata = hold_q;
   end
endmodule

// File: rtl/ixb_top.sv
module ixb_top #(
   parameter int AW         = 15,
   parameter int RST_CYCLES = 4,
   parameter bit MEM_SYNC   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_cs,
   input  logic          host_rd,
   input  logic          host_wr,
   input  logic [AW-1:0] host_addr,
   input  logic [7:0]    host_wdata,
   output logic [7:0]    host_rdata,
   output logic [AW-1:0] mem_addr,
   output logic          mem_we,
   output logic          mem_re,
   output logic [7:0]    mem_wdata,
   input  logic [7:0]    mem_rdata,
   output logic          soft_rst,
   output logic          ping_block
);
   import ixb_pkg::*;

   if (AW < 9 || AW > 16) begin : g_bad_aw
      $error("ixb_top: AW must lie between 9 and 16");
   end

   logic          rd_req, wr_req, busy;
   logic          pb_q, ai_q, ind_q;
   logic [7:0]    mode_rd, ptr_hi, ptr_lo, local_byte;
   logic [AW-1:0] ptr_q, tgt_addr;
   tgt_e          tgt;
   logic          is_data, mode_wr, rst_wr, step;

   assign rd_req = host_cs & host_rd & ~host_wr;
   assign wr_req = host_cs & host_wr;

   // Address decode
   always_comb begin
      tgt      = TGT_MEM;
      tgt_addr = host_addr;
      if (!ind_q) begin
         if (host_addr == '0) tgt = TGT_MODE;
      end else begin
         unique case (host_addr[1:0])
            2'd0: tgt = TGT_MODE;
            2'd1: tgt = TGT_PHI;
            2'd2: tgt = TGT_PLO;
            default: begin
               tgt_addr = ptr_q;
               tgt      = (ptr_q == '0) ? TGT_MODE : TGT_MEM;
            end
         endcase
      end
   end

   always_comb begin
      unique case (tgt)
         TGT_MODE: local_byte = mode_rd;
         TGT_PHI:  local_byte = ptr_hi;
         TGT_PLO:  local_byte = ptr_lo;
         default:  local_byte = 8'h00;
      endcase
      if (busy) local_byte = mode_rd;
   end

   assign is_data = ind_q & (host_addr[1:0] == 2'd3);
   assign mode_wr = wr_req & ~busy & (tgt == TGT_MODE);
   assign rst_wr  = mode_wr & host_wdata[MB_RST];
   assign step    = is_data & ai_q & (rd_req | wr_req) & ~busy & ~rst_wr;

   ixb_mode #(.RST_CYCLES(RST_CYCLES)) u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mode_wr),
      .wdata   (host_wdata),
      .busy    (busy),
      .pb      (pb_q),
      .ai      (ai_q),
      .ind     (ind_q),
      .rd_byte (mode_rd)
   );

   ixb_ptr #(.AW(AW)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (rst_wr),
      .ld_hi (wr_req & ~busy & (tgt == TGT_PHI)),
      .ld_lo (wr_req & ~busy & (tgt == TGT_PLO)),
      .step  (step),
      .wdata (host_wdata),
      .ptr   (ptr_q),
      .rd_hi (ptr_hi),
      .rd_lo (ptr_lo)
   );

   ixb_rdpath #(.MEM_SYNC(MEM_SYNC)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_local   (rd_req & (busy | (tgt != TGT_MEM))),
      .rd_mem     (mem_re),
      .local_byte (local_byte),
      .mem_rdata  (mem_rdata),
      .rdata      (host_rdata)
   );

   assign mem_addr   = tgt_addr;
   assign mem_re     = rd_req & ~busy & (tgt == TGT_MEM);
   assign mem_we     = wr_req & ~busy & (tgt == TGT_MEM);
   assign mem_wdata  = host_wdata;
   assign soft_rst   = busy;
   assign ping_block = pb_q;
endmodule

// File: rtl/ixb_chk.sv
module ixb_chk #(
   parameter int AW = 15
) (
   input logic          clk,
   input logic          rst_n,
   input logic          host_cs,
   input logic          host_rd,
   input logic          host_wr,
   input logic [AW-1:0] host_addr,
   input logic [AW-1:0] mem_addr,
   input logic          mem_we,
   input logic          mem_re,
   input logic          soft_rst,
   input logic          ind_q,
   input logic          ai_q,
   input logic [AW-1:0] ptr_q,
   input logic [7:0]    mode_rd
);
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re)); // R12

   AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> (!mem_we && !mem_re)); // R10

   AST_RST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(soft_rst) |-> (mode_rd == 8'h80 && ptr_q == '0)); // R9

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ind_q && ai_q && !soft_rst && host_cs && host_rd && !host_wr && host_addr[1:0] == 2'd3)
      |=> ptr_q == AW'($past(ptr_q) + 1'b1)); // R6

   AST_DIRECT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!ind_q && !soft_rst && host_cs && host_wr && host_addr != '0)
      |-> (mem_we && mem_addr == host_addr)); // R2

   AST_IND_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (ind_q && !soft_rst && host_cs && host_wr && host_addr[1:0] == 2'd3 && ptr_q != '0)
      |-> (mem_we && mem_addr == ptr_q)); // R5
endmodule

bind ixb_top ixb_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_cs   (host_cs),
   .host_rd   (host_rd),
   .host_wr   (host_wr),
   .host_addr (host_addr),
   .mem_addr  (mem_addr),
   .mem_we    (mem_we),
   .mem_re    (mem_re),
   .soft_rst  (soft_rst),
   .ind_q     (ind_q),
   .ai_q      (ai_q),
   .ptr_q     (ptr_q),
   .mode_rd   (mode_rd)
);

// File: tb/ixb_top_tb_top.sv
`timescale 1ns/1ps
module ixb_top_tb_top;
   localparam int AW   = 15;
   localparam int RSTC = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_cs = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [7:0]    host_wdata = '0;
   logic [7:0]    host_rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_we, mem_re, soft_rst, ping_block;
   logic [7:0]    mem_wdata;
   logic [7:0]    mem_q = '0;

   always #5 clk = ~clk;

   ixb_top #(.AW(AW), .RST_CYCLES(RSTC), .MEM_SYNC(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
      .mem_rdata(mem_q), .soft_rst(soft_rst), .ping_block(ping_block)
   );

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 13) ^ (a >> 5) ^ 8'h5A);
   endfunction

   // Internal byte space seen by the design (synchronous read)
   logic [7:0] dmem [int];
   always @(posedge clk) begin
      if (mem_re) mem_q <= dmem.exists(int'(mem_addr)) ? dmem[int'(mem_addr)] : pat(int'(mem_addr));
      if (mem_we) dmem[int'(mem_addr)] = mem_wdata;
   end

   // Reference model state
   logic [7:0] rmem [int];
   int    m_flags = 0, m_busy = 0, m_ptr = 0;
   bit    pend = 0;
   int    pend_val = 0;
   string pend_tag = "";
   int    checks = 0, errors = 0;
   bit    done = 0;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic cyc(input bit cs, input bit rd, input bit wr, input int a, input int wd,
                      input string tag);
      bit rdq, wrq, blk, ind, ai, exp_re, exp_we, step;
      int kind, ma, mode_rd;
      @(negedge clk);
      host_cs = cs; host_rd = rd; host_wr = wr;
      host_addr = AW'(a); host_wdata = 8'(wd);
      #1;
      if (pend) chk(pend_tag, "host_rdata", int'(host_rdata), pend_val);
      pend = 0;
      rdq = cs && rd && !wr;
      wrq = cs && wr;
      blk = (m_busy > 0);
      ind = (m_flags & 1) != 0;
      ai  = (m_flags & 2) != 0;
      mode_rd = (blk ? 8'h80 : 0) | m_flags;
      ma = a & 16'h7FFF;
      if (!ind) kind = (ma == 0) ? 0 : 3;
      else begin
         kind = a & 3;
         if (kind == 3) begin
            ma = m_ptr;
            if (m_ptr == 0) kind = 0;
         end
      end
      exp_re = rdq && !blk && kind == 3;
      exp_we = wrq && !blk && kind == 3;
      chk(tag, "mem_re", int'(mem_re), int'(exp_re));
      chk(tag, "mem_we", int'(mem_we), int'(exp_we));
      if (exp_re || exp_we) chk(tag, "mem_addr", int'(mem_addr), ma);
      if (exp_we) chk(tag, "mem_wdata", int'(mem_wdata), wd & 8'hFF);
      chk(tag, "soft_rst", int'(soft_rst), int'(blk));
      chk(tag, "ping_block", int'(ping_block), (m_flags >> 4) & 1);
      if (rdq) begin
         pend = 1; pend_tag = tag;
         if (blk) pend_val = mode_rd;
         else case (kind)
            0: pend_val = mode_rd;
            1: pend_val = m_ptr >> 8;
            2: pend_val = m_ptr & 8'hFF;
            default: pend_val = rmem.exists(ma) ? int'(rmem[ma]) : int'(pat(ma));
         endcase
      end
      if (blk) m_busy--;
      else begin
         step = ind && ((a & 3) == 3) && ai && (rdq || wrq);
         if (step) m_ptr = (m_ptr + 1) & 16'h7FFF;
         if (wrq) case (kind)
            0: if ((wd & 8'h80) != 0) begin
                  m_busy = RSTC; m_flags = 0; m_ptr = 0;
               end else m_flags = wd & 8'h13;
            1: m_ptr = (m_ptr & 8'hFF) | ((wd & 8'h7F) << 8);
            2: m_ptr = (m_ptr & 16'h7F00) | (wd & 8'hFF);
            default: rmem[ma] = 8'(wd);
         endcase
      end
   endtask

   task automatic wr(input int a, input int d, input string tag); cyc(1, 0, 1, a, d, tag); endtask
   task automatic rd(input int a, input string tag);              cyc(1, 1, 0, a, 0, tag); endtask
   task automatic idle(input string tag);                         cyc(0, 0, 0, 0, 0, tag); endtask
   task automatic set_ptr(input int p, input string tag);
      wr(16'h7F01, p >> 8, tag);
      wr(2, p & 8'hFF, tag);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1: reset state
      idle("R1"); rd(0, "R1"); idle("R1");
      // R2: direct mapping
      wr(16'h1234, 8'hA5, "R2"); rd(16'h1234, "R2"); rd(16'h0400, "R2"); idle("R2");
      for (int i = 1; i < 40; i++) begin
         wr((i * 811) & 16'h7FFF, i * 7, "R2");
         rd((i * 811) & 16'h7FFF, "R2");
      end
      // R11: back-to-back reads, then an idle gap
      rd(16'h1234, "R11"); rd(0, "R11"); rd(16'h7FFF, "R11"); idle("R11");
      // R12: read and write strobes together
      cyc(1, 1, 1, 16'h0100, 8'h3C, "R12"); rd(16'h0100, "R12"); idle("R12");
      // R3: mode register bits
      wr(0, 8'h12, "R3"); rd(0, "R3"); idle("R3");
      wr(0, 8'h6E, "R3"); rd(0, "R3");
      wr(0, 8'h13, "R3"); rd(16'h5A0C, "R3"); idle("R3");
      // R4: pointer registers, upper host bits ignored, top pointer bit dropped
      wr(16'h7FF1, 8'hC1, "R4"); wr(16'h1232, 8'h23, "R4");
      rd(1, "R4"); rd(2, "R4"); idle("R4");
      // R5 / R6: data port with auto-increment
      wr(3, 8'h11, "R5"); wr(3, 8'h22, "R5");
      set_ptr(16'h4123, "R5"); rd(3, "R5"); rd(3, "R5"); rd(2, "R6"); idle("R6");
      // R6: auto-increment off keeps the pointer
      wr(0, 8'h01, "R6"); rd(3, "R6"); rd(3, "R6"); wr(3, 8'h99, "R6"); rd(2, "R6"); rd(3, "R6");
      idle("R6");
      // R7: linear increment across region ends
      wr(0, 8'h03, "R7"); set_ptr(16'h5FFF, "R7"); wr(3, 8'hEE, "R7"); rd(1, "R7"); rd(2, "R7");
      set_ptr(16'h7FFF, "R7"); wr(3, 8'h77, "R7"); rd(1, "R7"); rd(2, "R7");
      set_ptr(16'h7FFF, "R7"); rd(3, "R7"); idle("R7");
      // R8: pointer 0 reaches the mode register
      set_ptr(0, "R8"); rd(3, "R8"); rd(2, "R8");
      set_ptr(0, "R8"); wr(3, 8'h13, "R8"); idle("R8"); rd(0, "R8"); idle("R8");
      // R9 / R10: soft reset through the mode register
      set_ptr(16'h2222, "R9"); wr(0, 8'h80, "R9");
      wr(3, 8'h55, "R10"); rd(1, "R10"); wr(0, 8'h13, "R10"); rd(16'h1234, "R10");
      idle("R9"); rd(0, "R9"); rd(16'h1234, "R9");
      wr(0, 8'h01, "R9"); rd(1, "R9"); rd(2, "R9"); idle("R9");
      // R9: reset written through the data port while auto-increment is on
      wr(0, 8'h03, "R9"); set_ptr(0, "R9"); wr(3, 8'h93, "R9");
      repeat (RSTC) idle("R10");
      wr(0, 8'h01, "R9"); rd(1, "R9"); rd(2, "R9"); rd(0, "R9"); idle("R9");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         errors++;
         $display("FAIL R11 watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule